// File: doc/BRIEF.md
# Brown-out Detector Mode Controller

This block sits between a supply brown-out comparator and the reset and interrupt logic of a chip. It decides from the current power-save state and the detector operating mode whether the comparator is powered. It turns the comparator's raw flag into a reset request, an immediate interrupt, or an interrupt that is held back until the core is awake again. The comparator runs in one of two ways. In continuous operation its flag is watched every cycle. In sampled operation the flag is read only on a slow tick and must be seen on consecutive samples before it counts.

At reset the block also checks the calibration-done value. When that value is clear, the core is held for a fixed calibration period and the bit is then set. When it is already set, the core is released at once and nothing is changed.

Power-state encoding on `pwrMode`: 0 = RUN, 1 = SLEEP, 2 = WAIT, 3 = RETENTION, 4 = BACKUP. Codes 5 to 7 are treated as deep states.

Top module: `bod_mode_guard`

## Requirements
- R1: `cmpEn` is 1 whenever `sampleMode` is 1, whatever the power state. With `sampleMode` 0 it is 1 only in RUN (0) and SLEEP (1), and 0 in WAIT (2), RETENTION (3) and BACKUP (4).
- R2: In continuous mode with the comparator enabled, a flag high in cycle t with `rstActEn` high gives `resetReq` high after the second clock edge, for one cycle per flagged cycle.
- R3: In continuous mode in RUN or SLEEP, a flag high in cycle t with `irqActEn` high gives `irqReq` high after the second clock edge, with no pending flag set.
- R4: While `cmpEn` is 0, a high `cmpFlag` produces no reset request, no interrupt and no pending flag.
- R5: In sampled mode the flag is captured only on cycles with `sampleTick` high. A brown-out counts only while the last SAMPLES captures (default 2) are all high. A single high capture between low ones has no effect.
- R6: In sampled mode in WAIT, RETENTION or BACKUP, a counted brown-out with `rstActEn` high raises `resetReq` one edge after it counts.
- R7: In sampled mode in WAIT, RETENTION or BACKUP, a counted brown-out with `irqActEn` high sets `irqPending` one edge after it counts and does not raise `irqReq`.
- R8: With `irqPending` set, on the first cycle the power state input is RUN or SLEEP after a deep state, `irqReq` is high after the next edge for exactly one cycle. `irqPending` stays set.
- R9: A high `pendClr` clears `irqPending` at the next edge. A new pending event in the same cycle wins.
- R10: After reset with `calDoneIn` 0, `coreHold` stays 1 for CAL_CYCLES (default 16) cycles after the first edge out of reset. It then falls and `calDone` becomes 1.
- R11: After reset with `calDoneIn` 1, `coreHold` falls at the first edge out of reset and `calDone` is 1 from then on.
- R12: During reset `resetReq`, `irqReq`, `irqPending` and `calDone` are 0 and `coreHold` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrMode | input | 3 | Power-save state code |
| sampleMode | input | 1 | 1 = sampled operation, 0 = continuous |
| cmpFlag | input | 1 | Raw comparator output, 1 = brown-out |
| rstActEn | input | 1 | Allow a brown-out to request reset |
| irqActEn | input | 1 | Allow a brown-out to request an interrupt |
| sampleTick | input | 1 | Slow sampling strobe |
| pendClr | input | 1 | Write-one-to-clear for the pending flag |
| calDoneIn | input | 1 | Stored calibration-done value seen at reset |
| cmpEn | output | 1 | Comparator power enable |
| resetReq | output | 1 | Reset request |
| irqReq | output | 1 | Interrupt request |
| irqPending | output | 1 | Held interrupt waiting for delivery |
| coreHold | output | 1 | Keeps the core in reset during calibration |
| calDone | output | 1 | Calibration-done bit |

## Verification
Continuous-mode pulses are driven in RUN, SLEEP and each deep state. This tells the immediate reset and interrupt paths apart from the gated-off comparator. Sampled-mode patterns contrast two agreeing captures with a lone high capture and with flag changes between ticks, which separates true sampling from edge watching. A deep-state event followed by a return to RUN and a clear strobe shows the held interrupt is both delayed and delivered once. Two resets with opposite calibration values measure the hold length.

// File: rtl/bod_mode_pkg.sv
package bod_mode_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_SLEEP  = 3'd1,
    PS_WAIT   = 3'd2,
    PS_RETAIN = 3'd3,
    PS_BACKUP = 3'd4
  } pwrState_e;

  typedef enum logic [1:0] {
    CAL_CHECK = 2'd0,
    CAL_BUSY  = 2'd1,
    CAL_DONE  = 2'd2
  } calPhase_e;

  typedef struct packed {
    logic cmpOn;        // comparator powered
    logic lowPwr;       // deep power-save state
    logic backToActive; // first cycle awake after a deep state
    logic sampleSel;    // sampled operation selected
  } bodStrobes_t;
endpackage

// File: rtl/bod_mode_ctrl.sv
module bod_mode_ctrl
  import bod_mode_pkg::*;
#(
  parameter int CAL_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  pwrMode,
  input  logic        sampleMode,
  input  logic        calDoneIn,
  output bodStrobes_t strb,
  output logic        coreHold,
  output logic        calDone
);
  localparam int CNT_W = $clog2(CAL_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAL_CYCLES - 1);

  logic       isActive;
  logic       wasLowQ;
  calPhase_e  phaseQ;
  logic [CNT_W-1:0] calCnt;

  // RUN and SLEEP are the awake states; every other code is deep
  assign isActive = (pwrMode == PS_RUN) || (pwrMode == PS_SLEEP);

  always_comb begin
    strb.sampleSel    = sampleMode;
    strb.lowPwr       = !isActive;
    strb.cmpOn        = sampleMode || isActive;
    strb.backToActive = isActive && wasLowQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wasLowQ <= 1'b0;
    else       wasLowQ <= !isActive;
  end

  // Reset-time calibration check and busy period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= CAL_CHECK;
      calCnt   <= '0;
      coreHold <= 1'b1;
      calDone  <= 1'b0;
    end else begin
      unique case (phaseQ)
        CAL_CHECK: begin
          calCnt <= '0;
          if (calDoneIn) begin
            phaseQ   <= CAL_DONE;
            coreHold <= 1'b0;
            calDone  <= 1'b1;
          end else begin
            phaseQ <= CAL_BUSY;
          end
        end
        CAL_BUSY: begin
          if (calCnt == CNT_LAST) begin
            phaseQ   <= CAL_DONE;
            coreHold <= 1'b0;
            calDone  <= 1'b1;
          end else begin
            calCnt <= calCnt + 1'b1;
          end
        end
        default: begin
          phaseQ <= CAL_DONE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bod_event_path.sv
module bod_event_path
  import bod_mode_pkg::*;
#(
  parameter int SAMPLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  bodStrobes_t strb,
  input  logic        cmpFlag,
  input  logic        sampleTick,
  input  logic        rstActEn,
  input  logic        irqActEn,
  input  logic        pendClr,
  output logic        resetReq,
  output logic        irqReq,
  output logic        irqPending
);
  localparam int SMP_W = (SAMPLES < 2) ? 2 : SAMPLES;

  logic [SMP_W-1:0] smpQ;
  logic contQ;
  logic brownEvt;
  logic irqNow;
  logic irqDefer;

  // Sample history: only advanced on the slow tick, flushed when unused
  always_ff @(posedge clk) begin
    if (!rstN || !strb.sampleSel) smpQ <= '0;
    else if (sampleTick)          smpQ <= {smpQ[SMP_W-2:0], cmpFlag};
  end

  // Continuous path: one register, gated by the comparator enable
  always_ff @(posedge clk) begin
    if (!rstN) contQ <= 1'b0;
    else       contQ <= strb.cmpOn && !strb.sampleSel && cmpFlag;
  end

  generate
    if (SAMPLES < 2) begin : g_oneSample
      assign brownEvt = strb.sampleSel ? smpQ[0] : contQ;
    end else begin : g_multiSample
      assign brownEvt = strb.sampleSel ? (&smpQ) : contQ;
    end
  endgenerate

  assign irqNow   = brownEvt && irqActEn && !strb.lowPwr;
  assign irqDefer = brownEvt && irqActEn && strb.lowPwr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq   <= 1'b0;
      irqReq     <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      resetReq <= brownEvt && rstActEn;
      irqReq   <= irqNow || (irqPending && strb.backToActive);
      if (irqDefer)     irqPending <= 1'b1;
      else if (pendClr) irqPending <= 1'b0;
    end
  end
endmodule

// File: rtl/bod_mode_guard.sv
module bod_mode_guard
  import bod_mode_pkg::*;
#(
  parameter int CAL_CYCLES = 16,
  parameter int SAMPLES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] pwrMode,
  input  logic       sampleMode,
  input  logic       cmpFlag,
  input  logic       rstActEn,
  input  logic       irqActEn,
  input  logic       sampleTick,
  input  logic       pendClr,
  input  logic       calDoneIn,
  output logic       cmpEn,
  output logic       resetReq,
  output logic       irqReq,
  output logic       irqPending,
  output logic       coreHold,
  output logic       calDone
);
  bodStrobes_t strb;

  bod_mode_ctrl #(.CAL_CYCLES(CAL_CYCLES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrMode   (pwrMode),
    .sampleMode(sampleMode),
    .calDoneIn (calDoneIn),
    .strb      (strb),
    .coreHold  (coreHold),
    .calDone   (calDone)
  );

  bod_event_path #(.SAMPLES(SAMPLES)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpFlag   (cmpFlag),
    .sampleTick(sampleTick),
    .rstActEn  (rstActEn),
    .irqActEn  (irqActEn),
    .pendClr   (pendClr),
    .resetReq  (resetReq),
    .irqReq    (irqReq),
    .irqPending(irqPending)
  );

  assign cmpEn = strb.cmpOn;
endmodule

// File: rtl/bod_mode_guard_chk.sv
module bod_mode_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pwrMode,
  input logic       sampleMode,
  input logic       rstActEn,
  input logic       pendClr,
  input logic       cmpEn,
  input logic       resetReq,
  input logic       irqReq,
  input logic       irqPending,
  input logic       coreHold,
  input logic       calDone
);
  // R4: a continuous-mode reset needs the comparator on two cycles before
  a_r4_off_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !$past(sampleMode)) |-> $past(cmpEn, 2));

  // R2: a reset request only follows an enabled reset action
  a_r2_reset_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(rstActEn));

  // R7: no interrupt is raised from a deep power state
  a_r7_no_irq_deep: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($past(pwrMode) <= 3'd1));

  // R9: a clear while awake empties the pending flag
  a_r9_clear_awake: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendClr) && ($past(pwrMode) <= 3'd1)) |-> !irqPending);

  // R10: hold and done never overlap
  a_r10_hold_excl: assert property (@(posedge clk) disable iff (!rstN)
    coreHold |-> !calDone);

  // R11: once calibration is done the hold never returns
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(calDone) |-> (calDone && !coreHold));
endmodule

bind bod_mode_guard bod_mode_guard_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pwrMode   (pwrMode),
  .sampleMode(sampleMode),
  .rstActEn  (rstActEn),
  .pendClr   (pendClr),
  .cmpEn     (cmpEn),
  .resetReq  (resetReq),
  .irqReq    (irqReq),
  .irqPending(irqPending),
  .coreHold  (coreHold),
  .calDone   (calDone)
);

// File: tb/test_bod_mode_guard.sv
module test_bod_mode_guard;
  localparam int CAL_N = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pwrMode = 3'd0;
  logic       sampleMode = 1'b0, cmpFlag = 1'b0, rstActEn = 1'b0, irqActEn = 1'b0;
  logic       sampleTick = 1'b0, pendClr = 1'b0, calDoneIn = 1'b0;
  logic       cmpEn, resetReq, irqReq, irqPending, coreHold, calDone;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic  r, i, p, c;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  bod_mode_guard i_bod_mode_guard (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .sampleMode(sampleMode),
    .cmpFlag(cmpFlag), .rstActEn(rstActEn), .irqActEn(irqActEn),
    .sampleTick(sampleTick), .pendClr(pendClr), .calDoneIn(calDoneIn),
    .cmpEn(cmpEn), .resetReq(resetReq), .irqReq(irqReq),
    .irqPending(irqPending), .coreHold(coreHold), .calDone(calDone)
  );

  task automatic check1(input string tag, input string what, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
    end
  endtask

  // Monitor: pops one expectation per cycle and compares it
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (resetReq !== it.r || irqReq !== it.i || irqPending !== it.p || cmpEn !== it.c) begin
        failures++;
        $display("FAIL %s rst/irq/pend/cmpEn actual=%b%b%b%b expected=%b%b%b%b",
                 it.tag, resetReq, irqReq, irqPending, cmpEn, it.r, it.i, it.p, it.c);
      end
    end
  end

  // Driver: applies one cycle of inputs and queues the outputs expected after the edge
  task automatic step(input logic [2:0] m, input logic s, f, re, ie, t, c,
                      input logic eR, eI, eP, eC, input string tag);
    @(negedge clk); #1;
    pwrMode = m; sampleMode = s; cmpFlag = f; rstActEn = re;
    irqActEn = ie; sampleTick = t; pendClr = c;
    expQ.push_back('{eR, eI, eP, eC, tag});
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic countHold(input logic cdi, input int expHold, input string tag);
    int highs = 0;
    @(negedge clk); #1; rstN = 1'b0; calDoneIn = cdi;
    repeat (3) @(negedge clk);
    check1("R12", "resetReq", resetReq, 1'b0);
    check1("R12", "irqReq", irqReq, 1'b0);
    check1("R12", "irqPending", irqPending, 1'b0);
    check1("R12", "coreHold", coreHold, 1'b1);
    check1("R12", "calDone", calDone, 1'b0);
    #1; rstN = 1'b1;
    for (int k = 0; k < CAL_N + 8; k++) begin
      @(negedge clk);
      if (coreHold) highs++;
    end
    checks++;
    if (highs != expHold) begin
      failures++;
      $display("FAIL %s hold cycles actual=%0d expected=%0d", tag, highs, expHold);
    end
    check1(tag, "calDone", calDone, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    endRun();
  end

  initial begin
    countHold(1'b0, CAL_N, "R10");
    countHold(1'b1, 0, "R11");

    // R2: continuous RUN reset path
    step(3'd0,0,1,1,0,0,0, 0,0,0,1, "R2");
    step(3'd0,0,0,1,0,0,0, 1,0,0,1, "R2");
    step(3'd0,0,0,1,0,0,0, 0,0,0,1, "R2");
    // R3: continuous SLEEP immediate interrupt
    step(3'd1,0,1,0,1,0,0, 0,0,0,1, "R3");
    step(3'd1,0,0,0,1,0,0, 0,1,0,1, "R3");
    step(3'd1,0,0,0,1,0,0, 0,0,0,1, "R3");
    // R4 / R1: continuous deep states, comparator off, flag ignored
    step(3'd2,0,1,1,1,0,0, 0,0,0,0, "R4");
    step(3'd3,0,1,1,1,0,0, 0,0,0,0, "R4");
    step(3'd4,0,1,1,1,0,0, 0,0,0,0, "R4");
    step(3'd0,0,0,1,1,0,0, 0,0,0,1, "R4");
    step(3'd0,0,0,1,1,0,0, 0,0,0,1, "R1");
    // R5: sampled RUN, two agreeing captures
    step(3'd0,1,1,1,0,1,0, 0,0,0,1, "R5");
    step(3'd0,1,1,1,0,0,0, 0,0,0,1, "R5");
    step(3'd0,1,1,1,0,1,0, 0,0,0,1, "R5");
    step(3'd0,1,0,1,0,0,0, 1,0,0,1, "R5");
    step(3'd0,1,0,1,0,1,0, 1,0,0,1, "R5");
    step(3'd0,1,0,1,0,0,0, 0,0,0,1, "R5");
    // R5: lone high capture is ignored
    step(3'd0,1,1,1,0,1,0, 0,0,0,1, "R5");
    step(3'd0,1,0,1,0,1,0, 0,0,0,1, "R5");
    step(3'd0,1,0,1,0,0,0, 0,0,0,1, "R5");
    // R7: sampled WAIT, interrupt held pending
    step(3'd2,1,1,0,1,1,0, 0,0,0,1, "R1");
    step(3'd2,1,1,0,1,1,0, 0,0,0,1, "R7");
    step(3'd2,1,0,0,1,0,0, 0,0,1,1, "R7");
    step(3'd2,1,0,0,1,1,0, 0,0,1,1, "R7");
    step(3'd2,1,0,0,1,1,0, 0,0,1,1, "R7");
    // R8: delivery on return to RUN, once
    step(3'd0,1,0,0,1,0,0, 0,1,1,1, "R8");
    step(3'd0,1,0,0,1,0,0, 0,0,1,1, "R8");
    // R9: clear
    step(3'd0,1,0,0,1,0,1, 0,0,0,1, "R9");
    step(3'd0,1,0,0,1,0,0, 0,0,0,1, "R9");
    // R6: sampled BACKUP, immediate reset
    step(3'd4,1,1,1,0,1,0, 0,0,0,1, "R6");
    step(3'd4,1,1,1,0,1,0, 0,0,0,1, "R6");
    step(3'd4,1,0,1,0,0,0, 1,0,0,1, "R6");
    step(3'd4,1,0,1,0,1,0, 1,0,0,1, "R6");
    step(3'd4,1,0,1,0,0,0, 0,0,0,1, "R6");
    step(3'd0,1,0,1,0,0,0, 0,0,0,1, "R8");

    repeat (3) @(negedge clk);
    endRun();
  end
endmodule